// File: doc/BRIEF.md
# Sign-Magnitude Sequential Shift-Add Multiplier

This block multiplies two sign-magnitude numbers, each made of a sign bit and an N-bit magnitude. It takes one clock cycle to load the operands and then N cycles of add-and-shift to form the product. The product sign is the exclusive-OR of the two operand signs. It is computed once, at load, and the magnitude datapath never touches it.

A cycle with `start` high while the block is idle captures the operands. During that cycle the multiplicand goes to a holding register and the multiplier goes to the low half of the product register. The accumulator is cleared and a step counter is set to N. Each following cycle looks at the low multiplier bit. When that bit is 1, the multiplicand is added to the accumulator and the carry out of the adder is kept. The carry, accumulator and multiplier are then shifted right together by one place.

When the counter runs out, `done` goes high. The 2N-bit magnitude (accumulator above, multiplier register below) and the sign then stay fixed until the next accepted start. The interface is a plain start/done pair and has no back-pressure.

Top module: `signmag_shiftadd_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0, `prod_mag` is all zeros and `prod_sign` is 0.
- R2: A cycle with `start`=1 and `busy`=0 loads the operands. In the next cycle `busy` is 1 and `done` is 0.
- R3: `done` goes to 1 exactly N+1 clock edges after the loading edge: one load edge plus N iteration edges. `busy` falls on that same edge, and `busy` and `done` are never both 1.
- R4: When `done` is 1, `prod_mag` equals the unsigned product of the multiplicand and multiplier magnitudes that were captured at load.
- R5: When `done` is 1, `prod_sign` is the XOR of the two captured operand signs (1 = negative). A zero magnitude with sign 1 is reported unchanged.
- R6: A `start` pulse while `busy` is 1 is ignored. It neither changes the result nor shortens or lengthens the operation.
- R7: While `done` is 1 and `start` is 0, `done`, `prod_mag` and `prod_sign` hold their values, whatever the operand inputs do.
- R8: A `start` while `done` is 1 begins a new operation. `done` drops on the next edge.
- R9: The operand inputs are sampled only on the loading edge. Changing them during an operation has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when not busy) |
| mcand_sign | input | 1 | Multiplicand sign, 1 = negative |
| mcand_mag | input | N | Multiplicand magnitude |
| mplier_sign | input | 1 | Multiplier sign, 1 = negative |
| mplier_mag | input | N | Multiplier magnitude |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid, held until the next start |
| prod_sign | output | 1 | Product sign |
| prod_mag | output | 2N | Product magnitude |

## Verification
Some internal faults appear as an early or late `done`: a wrong step-counter load, a missed decrement, or a start taken while busy. These show within N+1 cycles of the start. A bad carry capture or a bad shift path shows only in `prod_mag` at `done`. It shows only for operand pairs where a partial sum overflows or a multiplier bit pattern exercises that path, which is why the bench sweeps every magnitude pair with every sign combination at N=4. A sign fault appears at `done` on the first operation whose operand signs differ.

// File: rtl/smm_pkg.sv
package smm_pkg;
  function automatic int unsigned step_cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/smm_ctrl.sv
module smm_ctrl #(
  parameter int unsigned N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int unsigned SCW = smm_pkg::step_cnt_width(N);

  logic [SCW-1:0] steps_left;

  assign load = start & ~busy;
  assign step = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      steps_left <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else if (load) begin
      steps_left <= SCW'(N);
      busy       <= 1'b1;
      done       <= 1'b0;
    end else if (busy) begin
      steps_left <= steps_left - 1'b1;
      if (steps_left == SCW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/smm_addstage.sv
module smm_addstage #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] acc,
  input  logic [N-1:0] mcand,
  input  logic [N-1:0] mplier,
  output logic [N-1:0] acc_nxt,
  output logic [N-1:0] mplier_nxt
);
  logic [N:0]   partial;
  logic         carry_e;
  logic [N-1:0] addend;

  always_comb begin
    addend  = mplier[0] ? mcand : '0;
    partial = {1'b0, acc} + {1'b0, addend};
    carry_e = partial[N];
  end

  // Shift carry:acc:mplier right by one. The carry enters the accumulator
  // MSB and the accumulator LSB enters the multiplier MSB.
  assign acc_nxt = {carry_e, partial[N-1:1]};

  generate
    if (N > 1) begin : g_wide
      assign mplier_nxt = {partial[0], mplier[N-1:1]};
    end else begin : g_one
      assign mplier_nxt = partial[0];
    end
  endgenerate
endmodule

// File: rtl/smm_datapath.sv
module smm_datapath #(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           mcand_sign,
  input  logic [N-1:0]   mcand_mag,
  input  logic           mplier_sign,
  input  logic [N-1:0]   mplier_mag,
  output logic           prod_sign,
  output logic [2*N-1:0] prod_mag
);
  logic [N-1:0] reg_b;
  logic [N-1:0] reg_a;
  logic [N-1:0] reg_q;
  logic [N-1:0] a_nxt;
  logic [N-1:0] q_nxt;
  logic         sign_a;

  smm_addstage #(.N(N)) u_add (
    .acc        (reg_a),
    .mcand      (reg_b),
    .mplier     (reg_q),
    .acc_nxt    (a_nxt),
    .mplier_nxt (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_b  <= '0;
      reg_a  <= '0;
      reg_q  <= '0;
      sign_a <= 1'b0;
    end else if (load) begin
      reg_b  <= mcand_mag;
      reg_q  <= mplier_mag;
      reg_a  <= '0;
      sign_a <= mcand_sign ^ mplier_sign;
    end else if (step) begin
      reg_a <= a_nxt;
      reg_q <= q_nxt;
    end
  end

  assign prod_mag  = {reg_a, reg_q};
  assign prod_sign = sign_a;
endmodule

// File: rtl/signmag_shiftadd_mul.sv
module signmag_shiftadd_mul #(
  parameter int unsigned N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mcand_sign,
  input  logic [N-1:0]   mcand_mag,
  input  logic           mplier_sign,
  input  logic [N-1:0]   mplier_mag,
  output logic           busy,
  output logic           done,
  output logic           prod_sign,
  output logic [2*N-1:0] prod_mag
);
  logic load;
  logic step;

  smm_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  smm_datapath #(.N(N)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .step        (step),
    .mcand_sign  (mcand_sign),
    .mcand_mag   (mcand_mag),
    .mplier_sign (mplier_sign),
    .mplier_mag  (mplier_mag),
    .prod_sign   (prod_sign),
    .prod_mag    (prod_mag)
  );
endmodule

// File: rtl/smm_chk.sv
module smm_chk #(
  parameter int unsigned N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           mcand_sign,
  input logic [N-1:0]   mcand_mag,
  input logic           mplier_sign,
  input logic [N-1:0]   mplier_mag,
  input logic           busy,
  input logic           done,
  input logic           prod_sign,
  input logic [2*N-1:0] prod_mag
);
  localparam int unsigned CW = $clog2(N + 2);

  logic [CW-1:0]  cyc;
  logic [N-1:0]   cap_b;
  logic [N-1:0]   cap_q;
  logic           cap_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc   <= '0;
      cap_b <= '0;
      cap_q <= '0;
      cap_s <= 1'b0;
    end else if (start && !busy) begin
      cyc   <= '0;
      cap_b <= mcand_mag;
      cap_q <= mplier_mag;
      cap_s <= mcand_sign ^ mplier_sign;
    end else if (busy) begin
      cyc <= cyc + 1'b1;
    end
  end

  // R2
  load_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);

  // R3
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cyc == CW'(N));

  // R3
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R4
  prod_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod_mag == ((2*N)'(cap_b) * (2*N)'(cap_q)));

  // R5
  prod_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> prod_sign == cap_s);

  // R6
  ignore_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && cyc < CW'(N - 1) |=> busy);

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(prod_mag) && $stable(prod_sign));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && busy);
endmodule

bind signmag_shiftadd_mul smm_chk #(.N(N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .mcand_sign  (mcand_sign),
  .mcand_mag   (mcand_mag),
  .mplier_sign (mplier_sign),
  .mplier_mag  (mplier_mag),
  .busy        (busy),
  .done        (done),
  .prod_sign   (prod_sign),
  .prod_mag    (prod_mag)
);

// File: tb/signmag_shiftadd_mul_test.sv
module signmag_shiftadd_mul_test;
  localparam int unsigned N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           mcand_sign = 1'b0;
  logic [N-1:0]   mcand_mag = '0;
  logic           mplier_sign = 1'b0;
  logic [N-1:0]   mplier_mag = '0;
  logic           busy;
  logic           done;
  logic           prod_sign;
  logic [2*N-1:0] prod_mag;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  signmag_shiftadd_mul #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand_sign(mcand_sign), .mcand_mag(mcand_mag),
    .mplier_sign(mplier_sign), .mplier_mag(mplier_mag),
    .busy(busy), .done(done), .prod_sign(prod_sign), .prod_mag(prod_mag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input int a, input bit as_, input int b, input bit bs_, input bit poke);
    logic [2*N-1:0] exp_mag;
    logic           exp_sgn;
    exp_mag = (2*N)'(a * b);
    exp_sgn = as_ ^ bs_;
    @(negedge clk);
    start = 1'b1; mcand_mag = N'(a); mcand_sign = as_;
    mplier_mag = N'(b); mplier_sign = bs_;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy", 32'(busy), 32'd1);
    chk("R2/R8 done low", 32'(done), 32'd0);
    // R9: scramble operands while busy
    mcand_mag = ~N'(a); mplier_mag = N'(b) ^ N'(5);
    mcand_sign = ~as_; mplier_sign = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (poke && i == 1) start = 1'b1;  // R6: start while busy
      @(negedge clk);
      start = 1'b0;
      chk("R3 early done", 32'(done), 32'd0);
    end
    @(negedge clk);
    chk("R3 done at N+1", 32'(done), 32'd1);
    chk("R3 busy low", 32'(busy), 32'd0);
    chk("R4/R6/R9 magnitude", 32'(prod_mag), 32'(exp_mag));
    chk("R5 sign", 32'(prod_sign), 32'(exp_sgn));
    if (poke) begin
      // R7: held while idle with moving inputs
      mcand_mag = N'(b); mplier_mag = N'(a + 3);
      @(negedge clk);
      @(negedge clk);
      chk("R7 done held", 32'(done), 32'd1);
      chk("R7 magnitude held", 32'(prod_mag), 32'(exp_mag));
      chk("R7 sign held", 32'(prod_sign), 32'(exp_sgn));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 prod_mag", 32'(prod_mag), 32'd0);
    chk("R1 prod_sign", 32'(prod_sign), 32'd0);
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          run_op(a, s[0], b, s[1], ((a + b + s) % 3) == 0);
    // R5: negative zero kept
    run_op(0, 1'b1, 9, 1'b0, 1'b1);
    // R8 restart straight from done
    run_op(15, 1'b1, 15, 1'b1, 1'b0);
    run_op(7, 1'b0, 13, 1'b1, 1'b0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule